// File: doc/BRIEF.md
# Sample Readout Serializer with Run-Length Encoding

This block drains a finished capture from sample memory and turns it into a byte stream for a serial transmitter. Each stored sample is one word made of GROUPS channel groups of GROUP_W bits (4 x 8 by default). A per-group drop flag removes that group's byte from every word sent. The surviving bytes of a word are packed together and sent lowest group first. Samples leave newest first. The newest sample sits at the highest address of the capture window, and address 0 is sent last.

With run-length encoding switched on, consecutive samples that would transmit identically are merged. The first sample of a run is sent as usual. It is followed at once by a count word giving how many further copies came after it. The top bit of the last byte of every transmitted word tells the two word kinds apart: it is set in a count word and forced clear in a sample word. A run is cut when the next sample differs or when the count no longer fits in the remaining bits. A single-cycle done strobe closes every readout.

The block is started by a one-cycle start strobe. The read count, given in units of four samples, and the flag word are latched at that moment.

Top module: `sample_readout_serializer`

## Requirements
- R1: Flag bit g (0 to GROUPS-1) set drops channel group g (sample bits g*8+7..g*8) from every transmitted word, so a word is exactly as many bytes as there are groups with a clear flag.
- R2: The bytes of one word are sent lowest-numbered enabled group first, packed with no gaps.
- R3: A read count of C reads 4*C samples, one read per sample, at addresses 4*C-1 down to 0 in that order. Read data is taken one cycle after the read strobe.
- R4: With flag bit GROUPS (bit 4) clear, every sample is sent unchanged (its enabled groups), one word per sample, with no count words.
- R5: With flag bit 4 set, every sample word has bit 7 of its last transmitted byte forced to 0.
- R6: With flag bit 4 set, when a sample is followed by k further samples that would transmit identically (k > 0), the sample word is followed immediately by a count word. A count word has bit 7 of its last byte set and k in the remaining lower bits, lowest byte first. Samples that differ only in that marker bit or in dropped groups count as identical.
- R7: A count never exceeds 2^(8*E-1)-1 for E enabled groups. A longer run is closed at that count, and the next identical sample starts a new run with a fresh sample word.
- R8: While out_valid is high and out_ready low, out_valid stays high and out_data stays unchanged on the next cycle.
- R9: done is high for exactly one cycle: the cycle right after the clock edge that accepts the last byte. A read count of 0, or all groups dropped, gives a done pulse with no bytes.
- R10: A start strobe arriving while a readout is in progress has no effect on the stream in progress.
- R11: During and after reset, out_valid, done and mem_rd_en are low until a start is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle strobe that begins a readout |
| rd_count | input | CNT_W | Samples to send, in units of four |
| flags | input | GROUPS+1 | Bits GROUPS-1..0 drop a channel group; bit GROUPS enables run-length encoding |
| mem_rd_en | output | 1 | Sample memory read strobe |
| mem_addr | output | ADDR_W | Sample memory read address |
| mem_rd_data | input | GROUPS*GROUP_W | Read data, valid one cycle after mem_rd_en |
| out_valid | output | 1 | A byte is offered |
| out_ready | input | 1 | The transmitter takes the offered byte |
| out_data | output | GROUP_W | Offered byte |
| done | output | 1 | Pulse after the final byte is accepted |

## Verification
The assertions assume that the memory answers every read exactly one cycle later. They also assume that rd_count and flags only matter at the start strobe and that ADDR_W is wide enough for 4*C-1.

The bench's memory model is a registered array that always answers with one cycle of latency. It holds rd_count and flags steady except in the case that tests a stray start mid-run, and it sizes every capture well within the address space. It sweeps all sixteen drop masks with encoding off and on, under both continuous and irregular out_ready. The sweep data sets up runs, marker-bit-only differences and long constant stretches, so that count splitting is reached.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EVAL,
    ST_PUSH
  } rdo_state_e;

endpackage

// File: rtl/rdo_group_packer.sv
module rdo_group_packer #(
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 8,
  localparam int SW     = GROUPS * GROUP_W,
  localparam int NB_W   = $clog2(GROUPS + 1)
) (
  input  logic [SW-1:0]     sample_i,
  input  logic [GROUPS-1:0] drop_i,
  input  logic              rle_i,
  output logic [SW-1:0]     word_o,
  output logic [NB_W-1:0]   nbytes_o,
  output logic [SW-1:0]     marker_o,
  output logic [SW-1:0]     run_max_o
);

  logic [SW-1:0] packed_w;
  logic [SW-1:0] marker_w;

  // Compact the enabled groups toward bit 0 and locate the marker bit.
  always_comb begin
    int k;
    k        = 0;
    packed_w = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (!drop_i[g]) begin
        packed_w[k*GROUP_W +: GROUP_W] = sample_i[g*GROUP_W +: GROUP_W];
        k = k + 1;
      end
    end
    marker_w = '0;
    if (k != 0) marker_w[k*GROUP_W-1] = 1'b1;
    nbytes_o  = NB_W'(k);
    marker_o  = marker_w;
    run_max_o = (k != 0) ? (marker_w - SW'(1)) : '0;
    word_o    = rle_i ? (packed_w & ~marker_w) : packed_w;
  end

endmodule

// File: rtl/rdo_byte_shifter.sv
module rdo_byte_shifter #(
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 8,
  localparam int SW     = GROUPS * GROUP_W,
  localparam int NB_W   = $clog2(GROUPS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [SW-1:0]      word_i,
  input  logic [NB_W-1:0]    nbytes_i,
  output logic               busy_o,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [GROUP_W-1:0] out_data_o
);

  logic [SW-1:0]   word_q, word_d;
  logic [NB_W-1:0] left_q, left_d;
  logic            take;
  logic            upd_en;

  assign out_valid_o = (left_q != '0);
  assign busy_o      = out_valid_o;
  assign out_data_o  = word_q[GROUP_W-1:0];
  assign take        = out_valid_o && out_ready_i;
  assign upd_en      = load_i || take;

  always_comb begin
    word_d = word_q;
    left_d = left_q;
    if (load_i) begin
      word_d = word_i;
      left_d = nbytes_i;
    end else if (take) begin
      word_d = word_q >> GROUP_W;
      left_d = left_q - NB_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      left_q <= '0;
    end else if (upd_en) begin
      word_q <= word_d;
      left_q <= left_d;
    end
  end

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R8
  AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_o); // R2

endmodule

// File: rtl/sample_readout_serializer.sv
module sample_readout_serializer
  import rdo_pkg::*;
#(
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 8,
  parameter int CNT_W   = 8,
  parameter int ADDR_W  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [CNT_W-1:0]           rd_count,
  input  logic [GROUPS:0]            flags,
  output logic                       mem_rd_en,
  output logic [ADDR_W-1:0]          mem_addr,
  input  logic [GROUPS*GROUP_W-1:0]  mem_rd_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [GROUP_W-1:0]         out_data,
  output logic                       done
);

  localparam int SW    = GROUPS * GROUP_W;
  localparam int NB_W  = $clog2(GROUPS + 1);
  localparam int NUM_W = CNT_W + 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  // Control state
  rdo_state_e        state_q, state_d;
  logic [GROUPS-1:0] drop_q, drop_d;
  logic              rle_q, rle_d;
  logic [NUM_W-1:0]  remain_q, remain_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [SW-1:0]     prev_q, prev_d;
  logic [SW-1:0]     run_q, run_d;
  logic              have_q, have_d;
  logic              cnt_pend_q, cnt_pend_d;
  logic              smp_pend_q, smp_pend_d;
  logic [SW-1:0]     cnt_w_q, cnt_w_d;
  logic [SW-1:0]     smp_w_q, smp_w_d;

  // Datapath wires
  logic [SW-1:0]     pk_word;
  logic [NB_W-1:0]   pk_nbytes;
  logic [SW-1:0]     pk_marker;
  logic [SW-1:0]     pk_run_max;
  logic              load;
  logic [SW-1:0]     load_word;
  logic              busy;
  logic [NUM_W-1:0]  total;

  assign total    = {rd_count, 2'b00};
  assign mem_addr = addr_q;

  rdo_group_packer #(
    .GROUPS  (GROUPS),
    .GROUP_W (GROUP_W)
  ) u_packer (
    .sample_i  (mem_rd_data),
    .drop_i    (drop_q),
    .rle_i     (rle_q),
    .word_o    (pk_word),
    .nbytes_o  (pk_nbytes),
    .marker_o  (pk_marker),
    .run_max_o (pk_run_max)
  );

  rdo_byte_shifter #(
    .GROUPS  (GROUPS),
    .GROUP_W (GROUP_W)
  ) u_shifter (
    .clk         (clk),
    .rst_n       (rst_sn),
    .load_i      (load),
    .word_i      (load_word),
    .nbytes_i    (pk_nbytes),
    .busy_o      (busy),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_data_o  (out_data)
  );

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    drop_d     = drop_q;
    rle_d      = rle_q;
    remain_d   = remain_q;
    addr_d     = addr_q;
    prev_d     = prev_q;
    run_d      = run_q;
    have_d     = have_q;
    cnt_pend_d = cnt_pend_q;
    smp_pend_d = smp_pend_q;
    cnt_w_d    = cnt_w_q;
    smp_w_d    = smp_w_q;
    mem_rd_en  = 1'b0;
    load       = 1'b0;
    load_word  = '0;
    done       = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          drop_d     = flags[GROUPS-1:0];
          rle_d      = flags[GROUPS];
          remain_d   = total;
          addr_d     = ADDR_W'(total - NUM_W'(1));
          run_d      = '0;
          have_d     = 1'b0;
          cnt_pend_d = 1'b0;
          smp_pend_d = 1'b0;
          state_d    = ST_PUSH;
        end
      end

      ST_FETCH: begin
        mem_rd_en = 1'b1;
        state_d   = ST_EVAL;
      end

      ST_EVAL: begin
        remain_d = remain_q - NUM_W'(1);
        addr_d   = addr_q - ADDR_W'(1);
        if (!rle_q) begin
          smp_w_d    = pk_word;
          smp_pend_d = 1'b1;
        end else if (have_q && (pk_word == prev_q) && (run_q < pk_run_max)) begin
          run_d = run_q + SW'(1);
        end else begin
          cnt_pend_d = have_q && (run_q != '0);
          cnt_w_d    = run_q | pk_marker;
          smp_w_d    = pk_word;
          smp_pend_d = 1'b1;
          prev_d     = pk_word;
          have_d     = 1'b1;
          run_d      = '0;
        end
        state_d = ST_PUSH;
      end

      ST_PUSH: begin
        if (!busy) begin
          if (cnt_pend_q) begin
            load       = 1'b1;
            load_word  = cnt_w_q;
            cnt_pend_d = 1'b0;
          end else if (smp_pend_q) begin
            load       = 1'b1;
            load_word  = smp_w_q;
            smp_pend_d = 1'b0;
          end else if (remain_q != '0) begin
            state_d = ST_FETCH;
          end else if (run_q != '0) begin
            cnt_w_d    = run_q | pk_marker;
            cnt_pend_d = 1'b1;
            run_d      = '0;
          end else begin
            done    = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q    <= ST_IDLE;
      drop_q     <= '0;
      rle_q      <= 1'b0;
      remain_q   <= '0;
      addr_q     <= '0;
      prev_q     <= '0;
      run_q      <= '0;
      have_q     <= 1'b0;
      cnt_pend_q <= 1'b0;
      smp_pend_q <= 1'b0;
      cnt_w_q    <= '0;
      smp_w_q    <= '0;
    end else begin
      state_q    <= state_d;
      drop_q     <= drop_d;
      rle_q      <= rle_d;
      remain_q   <= remain_d;
      addr_q     <= addr_d;
      prev_q     <= prev_d;
      run_q      <= run_d;
      have_q     <= have_d;
      cnt_pend_q <= cnt_pend_d;
      smp_pend_q <= smp_pend_d;
      cnt_w_q    <= cnt_w_d;
      smp_w_q    <= smp_w_d;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    state_q == ST_IDLE |-> !out_valid); // R11
  AST_READ_SPACED: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_rd_en |=> !mem_rd_en); // R3
  AST_SAMPLE_MARKER: assert property (@(posedge clk) disable iff (!rst_sn)
    load && rle_q && !cnt_pend_q |-> (load_word & pk_marker) == '0); // R5
  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_sn)
    run_q <= pk_run_max); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done); // R9
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> !out_valid); // R9

endmodule

// File: tb/sample_readout_serializer_test.sv
`timescale 1ns/1ps
module sample_readout_serializer_test;

  localparam int CNT_W  = 8;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  rd_count = '0;
  logic [4:0]  flags = '0;
  logic        mem_rd_en;
  logic [9:0]  mem_addr;
  logic [31:0] mem_rd_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        done;

  logic [31:0] mem [DEPTH];

  always #2.5 clk = ~clk;

  sample_readout_serializer #(
    .GROUPS(4), .GROUP_W(8), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_count(rd_count),
    .flags(flags), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .done(done)
  );

  // One-cycle-latency sample memory
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr];

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  int done_cnt = 0;
  int done_cyc = -1;
  int last_hs = -1;
  int hold_err = 0;
  bit mon_en = 1'b0;
  bit always_ready = 1'b1;
  logic [7:0] lfsr = 8'hA5;
  logic pv = 1'b0, pr = 1'b0;
  logic [7:0] pd = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Monitor and ready generator, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (pv && !pr && (!out_valid || out_data != pd)) hold_err++;
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = always_ready ? 1'b1 : (lfsr[0] | lfsr[2]);
      if (out_valid && out_ready) begin
        got_q.push_back(out_data);
        last_hs = cyc;
      end
      pv = out_valid;
      pr = out_ready;
      pd = out_data;
    end
    if (cyc == 195000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] hash(input int x);
    logic [31:0] v;
    v = 32'(x) * 32'h9E37_79B1;
    return v ^ (v >> 13) ^ 32'h1234_8765;
  endfunction

  task automatic fill(input int pat);
    for (int a = 0; a < DEPTH; a++) begin
      case (pat)
        0: mem[a] = hash(a);
        1: mem[a] = hash(a / 3) ^ ((a % 2) ? 32'h8000_0000 : 32'h0);
        default: mem[a] = 32'h5A5A_3C3C;
      endcase
    end
  endtask

  // Reference word formation from the requirements (R1, R2, R5)
  task automatic pack_ref(input logic [31:0] s, input logic [3:0] dis, input bit rle,
                          output logic [31:0] w, output int nb, output logic [31:0] mark);
    w = '0;
    nb = 0;
    for (int g = 0; g < 4; g++) begin
      if (!dis[g]) begin
        w = w | (32'(s[g*8 +: 8]) << (8 * nb));
        nb++;
      end
    end
    mark = (nb == 0) ? 32'h0 : (32'h1 << (8 * nb - 1));
    if (rle) w = w & ~mark;
  endtask

  task automatic emit(input logic [31:0] w, input int nb);
    for (int b = 0; b < nb; b++) exp_q.push_back(w[b*8 +: 8]);
  endtask

  // R3 newest first, R4 verbatim, R6 count after sample, R7 count limit
  task automatic build_exp(input int c, input logic [3:0] dis, input bit rle);
    logic [31:0] w, prev, mark;
    int nb;
    int run;
    bit have;
    exp_q.delete();
    run = 0;
    have = 0;
    prev = '0;
    nb = 0;
    mark = '0;
    for (int a = c * 4 - 1; a >= 0; a--) begin
      pack_ref(mem[a], dis, rle, w, nb, mark);
      if (!rle) emit(w, nb);
      else if (have && w == prev && (32'(run) < mark - 32'h1) && nb != 0) run++;
      else begin
        if (have && run > 0) emit(32'(run) | mark, nb);
        emit(w, nb);
        prev = w;
        have = 1;
        run = 0;
      end
    end
    if (rle && run > 0) emit(32'(run) | mark, nb);
  endtask

  task automatic run_case(input int c, input logic [3:0] dis, input bit rle,
                          input string tag, input bit restart);
    int t;
    int bad;
    build_exp(c, dis, rle);
    got_q.delete();
    done_cnt = 0;
    hold_err = 0;
    last_hs = -1;
    @(negedge clk);
    rd_count = 8'(c);
    flags = {rle, dis};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      repeat (15) @(negedge clk);
      rd_count = 8'd1;
      flags = 5'b1_0101;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      rd_count = 8'(c);
      flags = {rle, dis};
    end
    t = 0;
    while (done_cnt == 0 && t < 30000) begin
      @(negedge clk);
      t++;
    end
    repeat (8) @(negedge clk);
    chk(got_q.size() == exp_q.size(), tag, "byte count", got_q.size(), exp_q.size());
    bad = -1;
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
    if (bad >= 0) chk(1'b0, tag, "byte content", got_q[bad], exp_q[bad]);
    else          chk(1'b1, tag, "byte content", 0, 0);
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    if (exp_q.size() > 0)
      chk(done_cyc == last_hs + 1, "R9", "done cycle after last byte", done_cyc, last_hs + 1);
    chk(hold_err == 0, "R8", "offer held while stalled", hold_err, 0);
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) mem[a] = '0;
    // R11: reset state
    repeat (4) @(negedge clk);
    chk(!out_valid && !done && !mem_rd_en, "R11", "outputs in reset",
        {out_valid, done, mem_rd_en}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!out_valid && !done && !mem_rd_en, "R11", "outputs after reset",
        {out_valid, done, mem_rd_en}, 0);
    mon_en = 1'b1;

    // R1 R2 R3 R4: every drop mask, encoding off
    fill(0);
    for (int d = 0; d < 16; d++) begin
      always_ready = (d % 2) == 0;
      run_case(3, 4'(d), 1'b0, "R1", 1'b0);
    end
    // R4 with a longer window and stalls
    always_ready = 1'b0;
    run_case(9, 4'h0, 1'b0, "R4", 1'b0);
    run_case(5, 4'h6, 1'b0, "R3", 1'b0);

    // R6: runs merged, every drop mask
    fill(1);
    for (int d = 0; d < 16; d++) begin
      always_ready = (d % 2) == 1;
      run_case(6, 4'(d), 1'b1, "R6", 1'b0);
    end
    // R5: no runs, marker bit cleared in every sample
    fill(0);
    run_case(4, 4'h0, 1'b1, "R5", 1'b0);
    run_case(4, 4'h3, 1'b1, "R5", 1'b0);

    // R7: long constant stretch, one group -> split at 127
    fill(2);
    always_ready = 1'b1;
    run_case(40, 4'hE, 1'b1, "R7", 1'b0);
    run_case(40, 4'hC, 1'b1, "R7", 1'b0);
    always_ready = 1'b0;
    run_case(40, 4'h7, 1'b1, "R7", 1'b0);

    // R9: empty readouts
    fill(0);
    run_case(0, 4'h0, 1'b0, "R9", 1'b0);
    run_case(2, 4'hF, 1'b0, "R9", 1'b0);
    run_case(2, 4'hF, 1'b1, "R9", 1'b0);

    // R10: stray start mid-run
    always_ready = 1'b0;
    run_case(8, 4'h0, 1'b0, "R10", 1'b1);
    fill(1);
    run_case(8, 4'h0, 1'b1, "R10", 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule